// File: doc/BRIEF.md
# Indirect protection control and capability register bank

This block holds the control state for a memory protection unit behind a two-port indirect window. Software first writes a register index to an operation port. It then reads or writes the 32-bit data port, which reaches whichever register that index selects. The bank contains three kinds of register. A read-only capability word reports the revision and the domain and map-register counts. A control word carries the protection enables. Each protection domain has a pair of registers that describe its table: a valid flag, a protect flag, a size code and a 40-bit base address aligned to 4 KB.

Every control bit and every domain field is also driven out as a port, for the protection logic nearby. Three control bits do not behave like plain storage. The cache-invalidate bit is a request that hardware retires when the cache reports that the invalidation is done. The limited secure-loader protection bit is forced on by a secure-init pulse, and software may clear it later. The memory-clear-disable bit ignores writes until memory has been enabled.

Top module: `prot_csr_bank`

## Requirements
- R1: After reset, every control output is 0, every domain output is 0, the index is 0, and the data port reads the capability word.
- R2: Index 0 reads as the capability word. Bits 7:0 are REVISION, bits 15:8 are the domain count (4), bits 23:16 are NUM_MAPS (3), and bits 31:24 are 0. With the defaults the word is 32'h0003_0401. A write to index 0 is ignored.
- R3: Index 1 is the control word. Bit 0 drives globalEn, bit 2 ioBlock, bit 3 mceEn and bit 6 probeDis, and each of these takes the written value. Bits 31:7 always read 0.
- R4: A write of 1 to control bit 4 sets invReq. A write of 0 to that bit leaves it unchanged. An invDone pulse clears it. If a write of 1 and invDone arrive in the same cycle, invReq stays 1.
- R5: A secInit pulse sets control bit 5 (slProtEn) to 1 in the next cycle, even when software writes 0 to it in that cycle. At any other time a write sets bit 5 to the written value.
- R6: Control bit 1 (memClrDis) takes a written value only while memEnabled is 1. Otherwise it holds its value.
- R7: Index 2+2n is the low register of domain n (n = 0..3). Bit 0 is valid, bit 1 is protect, bits 6:2 are the size, and bits 31:12 are base address bits 31:12. Bits 11:7 read 0. These fields drive domValid[n], domProtect[n], domSize[5n+4:5n] and domBase[28n+19:28n].
- R8: Index 3+2n is the high register of domain n. Bits 7:0 hold base address bits 39:32 and drive domBase[28n+27:28n+20]. Bits 31:8 read 0.
- R9: An index from 10 to 255 reads 0, and a write to it changes no register.
- R10: An index written in one cycle selects the register from the next cycle on. A data write in the same cycle goes to the previously selected register. The data port read follows the selected register with no delay, and a data write shows there in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opWrEn | input | 1 | Write strobe for the index (operation) port |
| opWrData | input | 8 | Register index |
| dataWrEn | input | 1 | Write strobe for the data port |
| dataWrData | input | 32 | Data port write value |
| dataRdData | output | 32 | Data port read value of the selected register |
| secInit | input | 1 | Secure-init pulse that forces slProtEn on |
| memEnabled | input | 1 | Memory enabled; unlocks memClrDis |
| invDone | input | 1 | Pulse reporting that the cache invalidation is complete |
| globalEn | output | 1 | Protection global enable |
| memClrDis | output | 1 | Memory clear on reset disabled |
| ioBlock | output | 1 | Block upstream I/O cycles |
| mceEn | output | 1 | Machine-check reporting enable |
| invReq | output | 1 | Cache invalidate request |
| slProtEn | output | 1 | Limited secure-loader protection enable |
| probeDis | output | 1 | Table-walk probe disable |
| domValid | output | 4 | Valid flag for each domain |
| domProtect | output | 4 | Protect flag for each domain |
| domSize | output | 20 | 5-bit size code for each domain |
| domBase | output | 112 | Base address bits 39:12 for each domain, 28 bits per domain |

## Verification
The cases hardest to reach from the ports are the collisions, where two sources act on one control bit in the same cycle. One is a software write of 1 to the invalidate bit in the same cycle as invDone. The other is a write of 0 to the secure-loader bit in the same cycle as secInit. A third is an index change in the same cycle as a data write, where the data must land at the old index. Directed steps set up each of these collisions on purpose. A long random run from a fixed seed then mixes index writes, data writes, the three side inputs and toggles of memEnabled. That run crosses these collisions again and crosses the lock on memory-clear-disable in both states. After every cycle the bench compares every output against a model.

// File: rtl/prot_csr_pkg.sv
package prot_csr_pkg;
  localparam int unsigned NUM_DOM = 4;
  localparam int unsigned SIZE_W  = 5;
  localparam int unsigned BASE_W  = 28;
  localparam int unsigned HI_W    = BASE_W - 20;
  localparam logic [31:0] LO_MASK = 32'hFFFF_F07F;
  localparam int unsigned CTRL_W  = 7;

  typedef struct packed {
    logic               ctrlWr;
    logic [NUM_DOM-1:0] loWr;
    logic [NUM_DOM-1:0] hiWr;
    logic               capSel;
    logic               ctrlSel;
    logic [NUM_DOM-1:0] loSel;
    logic [NUM_DOM-1:0] hiSel;
  } strobe_t;
endpackage

// File: rtl/prot_csr_ctrl.sv
module prot_csr_ctrl
  import prot_csr_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opWrEn,
  input  logic [IDX_W-1:0] opWrData,
  input  logic             dataWrEn,
  output strobe_t          strb
);
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN)       idxQ <= '0;
    else if (opWrEn) idxQ <= opWrData;
  end

  always_comb begin
    strb.capSel  = (idxQ == IDX_W'(0));
    strb.ctrlSel = (idxQ == IDX_W'(1));
    for (int n = 0; n < NUM_DOM; n++) begin
      strb.loSel[n] = (idxQ == IDX_W'(2 + 2 * n));
      strb.hiSel[n] = (idxQ == IDX_W'(3 + 2 * n));
    end
    strb.ctrlWr = dataWrEn && strb.ctrlSel;
    strb.loWr   = dataWrEn ? strb.loSel : '0;
    strb.hiWr   = dataWrEn ? strb.hiSel : '0;
  end

  // R10: an index write is the selection seen in the next cycle
  a_r10_index_load: assert property (@(posedge clk) disable iff (!rstN)
    opWrEn |=> idxQ == $past(opWrData));
endmodule

// File: rtl/prot_csr_regs.sv
module prot_csr_regs
  import prot_csr_pkg::*;
#(
  parameter int unsigned NUM_MAPS = 3,
  parameter logic [7:0]  REVISION = 8'h01
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [31:0]                dataWrData,
  input  logic                       secInit,
  input  logic                       memEnabled,
  input  logic                       invDone,
  output logic [31:0]                dataRdData,
  output logic [CTRL_W-1:0]          ctrlQ,
  output logic [NUM_DOM-1:0]         domValid,
  output logic [NUM_DOM-1:0]         domProtect,
  output logic [NUM_DOM*SIZE_W-1:0]  domSize,
  output logic [NUM_DOM*BASE_W-1:0]  domBase
);
  localparam logic [31:0] CAP_WORD = {8'h00, 8'(NUM_MAPS), 8'(NUM_DOM), REVISION};

  logic [31:0]   loQ [NUM_DOM];
  logic [HI_W-1:0] hiQ [NUM_DOM];
  logic [CTRL_W-1:0] ctrlD;

  always_comb begin
    ctrlD = ctrlQ;
    if (strb.ctrlWr) begin
      ctrlD[0] = dataWrData[0];
      ctrlD[2] = dataWrData[2];
      ctrlD[3] = dataWrData[3];
      ctrlD[5] = dataWrData[5];
      ctrlD[6] = dataWrData[6];
      if (memEnabled) ctrlD[1] = dataWrData[1];
    end
    if (strb.ctrlWr && dataWrData[4]) ctrlD[4] = 1'b1;
    else if (invDone)                 ctrlD[4] = 1'b0;
    if (secInit) ctrlD[5] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlD;
  end

  for (genvar n = 0; n < NUM_DOM; n++) begin : g_dom
    always_ff @(posedge clk) begin
      if (!rstN) begin
        loQ[n] <= '0;
        hiQ[n] <= '0;
      end else begin
        if (strb.loWr[n]) loQ[n] <= dataWrData & LO_MASK;
        if (strb.hiWr[n]) hiQ[n] <= dataWrData[HI_W-1:0];
      end
    end
    assign domValid[n]   = loQ[n][0];
    assign domProtect[n] = loQ[n][1];
    assign domSize[n*SIZE_W +: SIZE_W] = loQ[n][6:2];
    assign domBase[n*BASE_W +: BASE_W] = {hiQ[n], loQ[n][31:12]};
  end

  always_comb begin
    dataRdData = '0;
    if (strb.capSel)  dataRdData = CAP_WORD;
    if (strb.ctrlSel) dataRdData = 32'(ctrlQ);
    for (int n = 0; n < NUM_DOM; n++) begin
      if (strb.loSel[n]) dataRdData = loQ[n];
      if (strb.hiSel[n]) dataRdData = 32'(hiQ[n]);
    end
  end

  // R9: at most one register selected by the decoder
  a_r9_onehot_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capSel, strb.ctrlSel, strb.loSel, strb.hiSel}));
  a_r4_inv_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[4] && !invDone |=> ctrlQ[4]);
  a_r4_inv_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[4] && invDone && !(strb.ctrlWr && dataWrData[4]) |=> !ctrlQ[4]);
  a_r5_secinit_force: assert property (@(posedge clk) disable iff (!rstN)
    secInit |=> ctrlQ[5]);
  a_r6_memclr_lock: assert property (@(posedge clk) disable iff (!rstN)
    !memEnabled |=> $stable(ctrlQ[1]));
  a_r7_lo_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.loSel) |-> dataRdData[11:7] == 5'd0);
endmodule

// File: rtl/prot_csr_bank.sv
module prot_csr_bank
  import prot_csr_pkg::*;
#(
  parameter int unsigned NUM_MAPS = 3,
  parameter logic [7:0]  REVISION = 8'h01,
  parameter int unsigned IDX_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       opWrEn,
  input  logic [IDX_W-1:0]           opWrData,
  input  logic                       dataWrEn,
  input  logic [31:0]                dataWrData,
  output logic [31:0]                dataRdData,
  input  logic                       secInit,
  input  logic                       memEnabled,
  input  logic                       invDone,
  output logic                       globalEn,
  output logic                       memClrDis,
  output logic                       ioBlock,
  output logic                       mceEn,
  output logic                       invReq,
  output logic                       slProtEn,
  output logic                       probeDis,
  output logic [NUM_DOM-1:0]         domValid,
  output logic [NUM_DOM-1:0]         domProtect,
  output logic [NUM_DOM*SIZE_W-1:0]  domSize,
  output logic [NUM_DOM*BASE_W-1:0]  domBase
);
  strobe_t strb;
  logic [CTRL_W-1:0] ctrlQ;

  prot_csr_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .opWrEn(opWrEn), .opWrData(opWrData),
    .dataWrEn(dataWrEn), .strb(strb)
  );

  prot_csr_regs #(.NUM_MAPS(NUM_MAPS), .REVISION(REVISION)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .dataWrData(dataWrData),
    .secInit(secInit), .memEnabled(memEnabled), .invDone(invDone),
    .dataRdData(dataRdData), .ctrlQ(ctrlQ), .domValid(domValid),
    .domProtect(domProtect), .domSize(domSize), .domBase(domBase)
  );

  assign globalEn  = ctrlQ[0];
  assign memClrDis = ctrlQ[1];
  assign ioBlock   = ctrlQ[2];
  assign mceEn     = ctrlQ[3];
  assign invReq    = ctrlQ[4];
  assign slProtEn  = ctrlQ[5];
  assign probeDis  = ctrlQ[6];
endmodule

// File: tb/test_prot_csr_bank.sv
module test_prot_csr_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opWrEn = 1'b0, dataWrEn = 1'b0, secInit = 1'b0, memEnabled = 1'b0, invDone = 1'b0;
  logic [7:0] opWrData = '0;
  logic [31:0] dataWrData = '0;
  logic [31:0] dataRdData;
  logic globalEn, memClrDis, ioBlock, mceEn, invReq, slProtEn, probeDis;
  logic [3:0] domValid, domProtect;
  logic [19:0] domSize;
  logic [111:0] domBase;

  int nVec = 0, nErr = 0;
  logic [7:0]  mIdx;
  logic [6:0]  mCtrl;
  logic [31:0] mLo [4];
  logic [7:0]  mHi [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_csr_bank i_prot_csr_bank (
    .clk(clk), .rstN(rstN), .opWrEn(opWrEn), .opWrData(opWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData), .dataRdData(dataRdData),
    .secInit(secInit), .memEnabled(memEnabled), .invDone(invDone),
    .globalEn(globalEn), .memClrDis(memClrDis), .ioBlock(ioBlock), .mceEn(mceEn),
    .invReq(invReq), .slProtEn(slProtEn), .probeDis(probeDis),
    .domValid(domValid), .domProtect(domProtect), .domSize(domSize), .domBase(domBase)
  );

  function automatic logic [31:0] expRead(logic [7:0] idx);
    if (idx == 0) return 32'h0003_0401;
    if (idx == 1) return {25'd0, mCtrl};
    if (idx >= 2 && idx <= 9) begin
      if (idx[0] == 1'b0) return mLo[(idx - 2) / 2];
      return {24'd0, mHi[(idx - 3) / 2]};
    end
    return 32'd0;
  endfunction

  function automatic string tagOf(logic [7:0] idx);
    if (idx == 0) return "R2";
    if (idx == 1) return "R3";
    if (idx >= 2 && idx <= 9) return idx[0] ? "R8" : "R7";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk({tag, " read"}, dataRdData, expRead(mIdx));
    chk("R3 ctrl outputs", {28'd0, probeDis, mceEn, ioBlock, globalEn},
        {28'd0, mCtrl[6], mCtrl[3], mCtrl[2], mCtrl[0]});
    chk("R4 invReq", 32'(invReq), 32'(mCtrl[4]));
    chk("R5 slProtEn", 32'(slProtEn), 32'(mCtrl[5]));
    chk("R6 memClrDis", 32'(memClrDis), 32'(mCtrl[1]));
    for (int n = 0; n < 4; n++) begin
      chk("R7 domain low fields", {domValid[n], domProtect[n], domSize[n*5 +: 5], domBase[n*28 +: 20]},
          {mLo[n][0], mLo[n][1], mLo[n][6:2], mLo[n][31:12]});
      chk("R8 domain high field", 32'(domBase[n*28+20 +: 8]), 32'(mHi[n]));
    end
  endtask

  task automatic step(logic oe, logic [7:0] od, logic de, logic [31:0] dd,
                      logic sec, logic done, string tag);
    opWrEn = oe; opWrData = od; dataWrEn = de; dataWrData = dd;
    secInit = sec; invDone = done;
    if (de && mIdx == 1) begin
      mCtrl[0] = dd[0]; mCtrl[2] = dd[2]; mCtrl[3] = dd[3];
      mCtrl[5] = dd[5]; mCtrl[6] = dd[6];
      if (memEnabled) mCtrl[1] = dd[1];
    end
    if (de && mIdx == 1 && dd[4]) mCtrl[4] = 1'b1;
    else if (done) mCtrl[4] = 1'b0;
    if (sec) mCtrl[5] = 1'b1;
    if (de && mIdx >= 2 && mIdx <= 9) begin
      if (mIdx[0] == 1'b0) mLo[(mIdx - 2) / 2] = dd & 32'hFFFF_F07F;
      else mHi[(mIdx - 3) / 2] = dd[7:0];
    end
    if (oe) mIdx = od;
    @(negedge clk);
    opWrEn = 0; dataWrEn = 0; secInit = 0; invDone = 0;
    #1;
    checkAll(tag);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    logic [7:0] ri;
    void'($urandom(32'd1234));
    mIdx = 0; mCtrl = 0;
    for (int n = 0; n < 4; n++) begin mLo[n] = 0; mHi[n] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checkAll("R1 reset");
    chk("R1 reset capability", dataRdData, 32'h0003_0401);
    // R2: capability write ignored
    step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R2 cap write ignored");
    // R3: control write, reserved bits read zero
    step(1, 1, 0, 0, 0, 0, "R10 index select");
    step(0, 0, 1, 32'hFFFF_FF4D, 0, 0, "R3 control write");
    // R4: write 0 has no effect, then invDone clears, then collision
    step(0, 0, 1, 32'h0000_0010, 0, 0, "R4 inv set");
    step(0, 0, 1, 32'h0000_0000, 0, 0, "R4 write zero keeps inv");
    step(0, 0, 0, 0, 0, 1, "R4 invDone clears");
    step(0, 0, 1, 32'h0000_0010, 0, 1, "R4 set wins over done");
    // R5: secInit over a write of zero, then software clear
    step(0, 0, 1, 32'h0000_0000, 1, 0, "R5 secInit beats write");
    step(0, 0, 1, 32'h0000_0000, 0, 0, "R5 software clear");
    // R6: locked then unlocked
    step(0, 0, 1, 32'h0000_0002, 0, 0, "R6 locked write");
    memEnabled = 1;
    step(0, 0, 1, 32'h0000_0002, 0, 0, "R6 unlocked write");
    memEnabled = 0;
    step(0, 0, 1, 32'h0000_0000, 0, 0, "R6 locked clear ignored");
    // R10: index change with data write goes to old index
    step(1, 2, 1, 32'h0000_0041, 0, 0, "R10 write to old index");
    step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R7 low write");
    step(1, 9, 0, 0, 0, 0, "R10 index select");
    step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R8 high write");
    // R9: unmapped indices
    step(1, 8'd10, 0, 0, 0, 0, "R9 select");
    step(0, 0, 1, 32'hDEAD_BEEF, 0, 0, "R9 write ignored");
    step(1, 8'd255, 0, 0, 0, 0, "R9 select top");
    step(0, 0, 1, 32'h1234_5678, 0, 0, "R9 write ignored top");
    for (int i = 0; i < 12; i++) step(1, 8'(i), 0, 0, 0, 0, tagOf(8'(i)));
    // random mix
    for (int i = 0; i < 3000; i++) begin
      r = $urandom;
      ri = (r[3:0] < 4'd12) ? 8'(r[3:0]) : 8'($urandom);
      if (r[20:18] == 0) memEnabled = ~memEnabled;
      step(r[4], ri, r[5] | r[6], $urandom, r[9:7] == 0, r[12:10] == 0, tagOf(mIdx));
    end
    finishRun();
  end
endmodule